// File: doc/BRIEF.md
# Lane Address Register Load/Store Unit

This unit sits beside four execution lanes that each carry a small private data stack. It owns one 32-bit address register per lane and carries out the lane operations that touch those registers or data memory. Supported operations are a load or store at a register plus a small unsigned offset, a load whose address is another lane's stack top, copying a register onto a stack, overwriting a register from a stack, and adding a stack value to a register. Memory addresses count 32-bit words, so an offset of 0 to 15 spans a whole cache line.

All four lanes present one opcode each in the same cycle. Any lane may name any lane's register. Every register read uses the value held before the instruction began. Memory accesses go out over a single word-addressed port, one per cycle, in rising lane order. `stall` holds the lanes while the accesses run. All results appear together as push and pop requests toward the lane stacks in the one cycle where `stall` is low. Register writes also take effect at the clock edge that ends that cycle.

Top module: `aru_lsu`

## Requirements
- R1: After reset every address register reads 0, and `stall`, `mem_req`, `push` and `pop` are all low.
- R2: Opcode `00 ss iiii` (lane field in bits 5:4, unsigned offset in bits 3:0) reads the memory word at register ss plus the offset and pushes it on the issuing lane's stack.
- R3: Opcode `01 ss iiii` writes the issuing lane's top to the memory word at register ss plus the offset and pops that lane's stack.
- R4: Opcode `100000ss` reads the memory word addressed by lane ss's top and pushes it on the issuing lane's stack.
- R5: Opcode `100001ss` pushes the value of register ss on the issuing lane's stack and makes no memory access.
- R6: Opcode `100010ss` loads register ss with the issuing lane's top and pops that lane. Opcode `100011ss` adds the issuing lane's top to register ss and neither pushes nor pops.
- R7: Every register read within an instruction sees the value from before that instruction, even when another lane writes the same register in it.
- R8: When several lanes write the same register in one instruction, the write from the highest-numbered lane is kept.
- R9: With n > 0 memory operations, one request goes out per cycle in rising lane order and `stall` is high for exactly n+1 cycles. With none, `stall` stays low. No push or pop is given while `stall` is high.
- R10: A lane whose valid bit is low, or whose opcode starts with 1 and has bits 6:4 not equal to 000, gives no push, no pop, no memory request and no register change.
- R11: Offset and add arithmetic on addresses wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 4 | Per-lane opcode valid, held while `stall` is high |
| op_code | input | 32 | Lane k opcode in bits 8k+7:8k, held while `stall` is high |
| lane_top | input | 128 | Lane k stack top in bits 32k+31:32k |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| stall | output | 1 | Lanes must hold their inputs |
| push | output | 4 | Per-lane push request |
| pop | output | 4 | Per-lane pop request |
| push_data | output | 128 | Lane k push value in bits 32k+31:32k |

## Verification
The bench first uses register-only words, where all four lanes set or fetch at once. These show that lanes are not confused and that no stall appears. It then runs memory words holding two and three accesses in scattered lanes, which checks the issue order, the n+1 stall length and the routing of load data back to the right lane. Words where lanes collide on one register separate the old-value read rule from the highest-lane-wins rule. Words near 2^32, and words with invalid or unassigned opcodes, cover address wrap and the no-effect cases.

// File: rtl/aru_pkg.sv
package aru_pkg;
  localparam int NLANE = 4;
  localparam int LIDX  = $clog2(NLANE);
  localparam int DW    = 32;
  localparam int OFFW  = 4;

  typedef logic [DW-1:0] word_t;

  typedef enum logic [2:0] {
    K_NONE, K_LDOFF, K_STOFF, K_LDTOP, K_FETCH, K_SET, K_ADD
  } op_kind_e;

  typedef struct packed {
    op_kind_e        kind;
    logic [LIDX-1:0] tgt;
    logic [OFFW-1:0] off;
  } op_dec_t;

  // Split an 8-bit lane opcode into kind, target lane and offset.
  function automatic op_dec_t decode_op(input logic [7:0] op);
    op_dec_t d;
    d.kind = K_NONE;
    d.off  = op[OFFW-1:0];
    d.tgt  = op[7] ? op[LIDX-1:0] : op[5:4];
    if (!op[7]) begin
      d.kind = op[6] ? K_STOFF : K_LDOFF;
    end else if (op[6:4] == 3'b000) begin
      case (op[3:2])
        2'd0:    d.kind = K_LDTOP;
        2'd1:    d.kind = K_FETCH;
        2'd2:    d.kind = K_SET;
        default: d.kind = K_ADD;
      endcase
    end
    return d;
  endfunction

  // Base register plus unsigned offset, word units, wraps.
  function automatic word_t offset_ea(input word_t base, input logic [OFFW-1:0] off);
    return base + word_t'(off);
  endfunction

  // Register update for the add form, wraps.
  function automatic word_t adr_sum(input word_t base, input word_t delta);
    return base + delta;
  endfunction

  // Index of the lowest set bit (0 when none).
  function automatic logic [LIDX-1:0] lowest_lane(input logic [NLANE-1:0] m);
    logic [LIDX-1:0] r;
    r = '0;
    for (int i = NLANE - 1; i >= 0; i--) begin
      if (m[i]) r = LIDX'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/aru_lane_dec.sv
module aru_lane_dec
  import aru_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic            valid,
  input  logic [7:0]      op,
  input  word_t           adr_q  [NLANE],
  input  word_t           top_in [NLANE],
  output logic            mem_use,
  output logic            mem_wr,
  output word_t           mem_addr,
  output word_t           mem_wdata,
  output logic            push_req,
  output logic            push_from_mem,
  output word_t           push_val,
  output logic            pop_req,
  output logic            aw_en,
  output logic [LIDX-1:0] aw_tgt,
  output word_t           aw_val
);
  op_dec_t  d;
  op_kind_e k;

  always_comb begin
    d = decode_op(op);
    k = valid ? d.kind : K_NONE;
  end

  assign mem_use       = (k == K_LDOFF) || (k == K_STOFF) || (k == K_LDTOP);
  assign mem_wr        = (k == K_STOFF);
  assign mem_addr      = (k == K_LDTOP) ? top_in[d.tgt] : offset_ea(adr_q[d.tgt], d.off);
  assign mem_wdata     = top_in[LANE];
  assign push_from_mem = (k == K_LDOFF) || (k == K_LDTOP);
  assign push_req      = push_from_mem || (k == K_FETCH);
  assign push_val      = adr_q[d.tgt];
  assign pop_req       = (k == K_STOFF) || (k == K_SET);
  assign aw_en         = (k == K_SET) || (k == K_ADD);
  assign aw_tgt        = d.tgt;
  assign aw_val        = (k == K_ADD) ? adr_sum(adr_q[d.tgt], top_in[LANE]) : top_in[LANE];
endmodule

// File: rtl/aru_mem_seq.sv
module aru_mem_seq
  import aru_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLANE-1:0] use_vec,
  input  logic [NLANE-1:0] wr_vec,
  input  word_t            addr_l  [NLANE],
  input  word_t            wdata_l [NLANE],
  input  word_t            mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output word_t            mem_addr,
  output word_t            mem_wdata,
  output logic             stall,
  output word_t            rbuf [NLANE]
);
  localparam int CW = $clog2(NLANE + 2) + 1;

  logic             busy_q, tail_q, rd_pend_q;
  logic [LIDX-1:0]  rd_lane_q;
  logic [NLANE-1:0] pend_q, pending, pend_next;
  logic [LIDX-1:0]  cur_lane;
  logic             issue;
  logic [CW-1:0]    stall_cnt_q;

  assign pending   = busy_q ? pend_q : use_vec;
  assign issue     = |pending;
  assign cur_lane  = lowest_lane(pending);
  assign pend_next = pending & ~(NLANE'(1) << cur_lane);

  assign mem_req   = issue;
  assign mem_we    = issue && wr_vec[cur_lane];
  assign mem_addr  = addr_l[cur_lane];
  assign mem_wdata = wdata_l[cur_lane];
  assign stall     = issue || tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      tail_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_lane_q <= '0;
      pend_q    <= '0;
    end else begin
      busy_q    <= stall;
      tail_q    <= issue && (pend_next == '0);
      rd_pend_q <= issue && !wr_vec[cur_lane];
      rd_lane_q <= cur_lane;
      pend_q    <= issue ? pend_next : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLANE; i++) rbuf[i] <= '0;
    end else if (rd_pend_q) begin
      rbuf[rd_lane_q] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     stall_cnt_q <= '0;
    else if (stall) stall_cnt_q <= stall_cnt_q + 1'b1;
    else            stall_cnt_q <= '0;
  end

  // R9: later requests of one instruction come from higher lanes
  p_lane_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && busy_q) |-> (cur_lane > $past(cur_lane)));
  // R9: a stall never lasts beyond one cycle per lane plus the tail
  p_stall_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_cnt_q <= CW'(NLANE)));
  // R9: the tail cycle carries no request
  p_tail_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q |-> !mem_req);
  // R2: read data is captured only after a read request
  p_read_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend_q |-> $past(mem_req && !mem_we));
endmodule

// File: rtl/aru_adr_file.sv
module aru_adr_file
  import aru_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [NLANE-1:0] aw_en,
  input  logic [LIDX-1:0]  aw_tgt [NLANE],
  input  word_t            aw_val [NLANE],
  output word_t            adr_q  [NLANE]
);
  for (genvar r = 0; r < NLANE; r++) begin : g_reg
    logic  hit;
    word_t nval;

    // Later lanes overwrite earlier ones: highest lane wins.
    always_comb begin
      hit  = 1'b0;
      nval = adr_q[r];
      for (int l = 0; l < NLANE; l++) begin
        if (aw_en[l] && (aw_tgt[l] == LIDX'(r))) begin
          hit  = 1'b1;
          nval = aw_val[l];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)            adr_q[r] <= '0;
      else if (commit && hit) adr_q[r] <= nval;
    end

    // R8: the top lane's write to this register is the one kept
    p_top_lane_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && aw_en[NLANE-1] && (aw_tgt[NLANE-1] == LIDX'(r)))
      |=> (adr_q[r] == $past(aw_val[NLANE-1])));
    // R7: registers are frozen while an instruction is stalled
    p_hold_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(adr_q[r]));
  end
endmodule

// File: rtl/aru_lsu.sv
module aru_lsu
  import aru_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLANE-1:0]      op_valid,
  input  logic [8*NLANE-1:0]    op_code,
  input  logic [DW*NLANE-1:0]   lane_top,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [DW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  stall,
  output logic [NLANE-1:0]      push,
  output logic [NLANE-1:0]      pop,
  output logic [DW*NLANE-1:0]   push_data
);
  word_t            top_in    [NLANE];
  word_t            adr_q     [NLANE];
  word_t            addr_l    [NLANE];
  word_t            wdata_l   [NLANE];
  word_t            push_val  [NLANE];
  word_t            aw_val    [NLANE];
  word_t            rbuf      [NLANE];
  logic [LIDX-1:0]  aw_tgt    [NLANE];
  logic [NLANE-1:0] use_vec, wr_vec, push_req, push_mem, pop_req, aw_en;
  logic             commit;
  logic             past_ok_q;

  assign commit = !stall;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign top_in[l] = lane_top[DW*l +: DW];

    aru_lane_dec #(.LANE(l)) u_dec (
      .valid         (op_valid[l]),
      .op            (op_code[8*l +: 8]),
      .adr_q         (adr_q),
      .top_in        (top_in),
      .mem_use       (use_vec[l]),
      .mem_wr        (wr_vec[l]),
      .mem_addr      (addr_l[l]),
      .mem_wdata     (wdata_l[l]),
      .push_req      (push_req[l]),
      .push_from_mem (push_mem[l]),
      .push_val      (push_val[l]),
      .pop_req       (pop_req[l]),
      .aw_en         (aw_en[l]),
      .aw_tgt        (aw_tgt[l]),
      .aw_val        (aw_val[l])
    );

    assign push[l]              = commit && push_req[l];
    assign pop[l]               = commit && pop_req[l];
    assign push_data[DW*l +: DW] = push_mem[l] ? rbuf[l] : push_val[l];
  end

  aru_mem_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .use_vec   (use_vec),
    .wr_vec    (wr_vec),
    .addr_l    (addr_l),
    .wdata_l   (wdata_l),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .stall     (stall),
    .rbuf      (rbuf)
  );

  aru_adr_file u_adr (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .aw_en  (aw_en),
    .aw_tgt (aw_tgt),
    .aw_val (aw_val),
    .adr_q  (adr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // R10: an idle word after a finished one starts nothing
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && !$past(stall) && (op_valid == '0))
    |-> (!mem_req && !stall && (push == '0) && (pop == '0)));
endmodule

// File: tb/tb_aru_lsu.sv
module tb_aru_lsu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op_valid = '0;
  logic [31:0]  op_code = '0;
  logic [127:0] lane_top = '0;
  logic         mem_req, mem_we, stall;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic [3:0]   push, pop;
  logic [127:0] push_data;

  always #4 clk = ~clk;

  aru_lsu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .lane_top(lane_top), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stall(stall), .push(push), .pop(pop), .push_data(push_data)
  );

  // Word memory, one-cycle read latency.
  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_adr [4];

  logic [3:0]  g_push, g_pop;
  logic [31:0] g_data [4];
  logic [31:0] g_acc_addr [8];
  logic        g_acc_we [8];
  int          g_nacc, g_stall_cyc, g_quiet_bad;
  logic        g_req0;

  function automatic logic [7:0] e_ld(input int s, input int i);  return {2'b00, 2'(s), 4'(i)}; endfunction
  function automatic logic [7:0] e_st(input int s, input int i);  return {2'b01, 2'(s), 4'(i)}; endfunction
  function automatic logic [7:0] e_ldt(input int s); return {6'b100000, 2'(s)}; endfunction
  function automatic logic [7:0] e_fe(input int s);  return {6'b100001, 2'(s)}; endfunction
  function automatic logic [7:0] e_set(input int s); return {6'b100010, 2'(s)}; endfunction
  function automatic logic [7:0] e_add(input int s); return {6'b100011, 2'(s)}; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] v,
                     input logic [7:0] o0, input logic [7:0] o1,
                     input logic [7:0] o2, input logic [7:0] o3,
                     input logic [31:0] t0, input logic [31:0] t1,
                     input logic [31:0] t2, input logic [31:0] t3);
    @(negedge clk);
    op_valid = v;
    op_code  = {o3, o2, o1, o0};
    lane_top = {t3, t2, t1, t0};
    #1;
    g_req0 = mem_req;
    g_nacc = 0; g_stall_cyc = 0; g_quiet_bad = 0;
    while (stall && g_stall_cyc < 20) begin
      if (push != 0 || pop != 0) g_quiet_bad++;
      if (mem_req) begin
        g_acc_addr[g_nacc] = mem_addr;
        g_acc_we[g_nacc]   = mem_we;
        g_nacc++;
      end
      g_stall_cyc++;
      @(negedge clk); #1;
    end
    g_push = push;
    g_pop  = pop;
    for (int k = 0; k < 4; k++) g_data[k] = push_data[32*k +: 32];
    @(posedge clk); #1;
    op_valid = '0;
  endtask

  task automatic fetch_all(input string tag);
    run(4'hF, e_fe(0), e_fe(1), e_fe(2), e_fe(3), 0, 0, 0, 0);
    chk({tag, " fetch no stall"}, 32'(g_stall_cyc), 0);
    chk({tag, " fetch push"}, 32'(g_push), 32'hF);
    for (int k = 0; k < 4; k++) chk({tag, " adr value"}, g_data[k], exp_adr[k]);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 stall", 32'(stall), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 push/pop", 32'({push, pop}), 0);
    for (int k = 0; k < 4; k++) exp_adr[k] = 0;
    fetch_all("R1 R5");
    chk("R5 fetch makes no access", 32'(g_nacc), 0);
  endtask

  task automatic t_set_and_cross_fetch;
    run(4'hF, e_set(0), e_set(1), e_set(2), e_set(3), 10, 20, 30, 40);
    chk("R6 set pops all", 32'(g_pop), 32'hF);
    chk("R6 set no push", 32'(g_push), 0);
    chk("R9 no stall without memory", 32'(g_stall_cyc), 0);
    exp_adr[0] = 10; exp_adr[1] = 20; exp_adr[2] = 30; exp_adr[3] = 40;
    run(4'hF, e_fe(3), e_fe(2), e_fe(1), e_fe(0), 0, 0, 0, 0);
    chk("R5 lane0 reads adr3", g_data[0], 40);
    chk("R5 lane1 reads adr2", g_data[1], 30);
    chk("R5 lane2 reads adr1", g_data[2], 20);
    chk("R5 lane3 reads adr0", g_data[3], 10);
  endtask

  task automatic t_store;
    run(4'b0101, e_st(1, 5), 8'h00, e_st(0, 0), 8'h00, 32'hAAAA, 0, 32'hBBBB, 0);
    chk("R9 stall n+1 (2 stores)", 32'(g_stall_cyc), 3);
    chk("R9 access count", 32'(g_nacc), 2);
    chk("R3 lane0 address first", g_acc_addr[0], 25);
    chk("R3 lane2 address second", g_acc_addr[1], 10);
    chk("R3 both writes", 32'({g_acc_we[0], g_acc_we[1]}), 32'b11);
    chk("R3 pops", 32'(g_pop), 32'b0101);
    chk("R9 quiet during stall", 32'(g_quiet_bad), 0);
    chk("R3 word 25", mem[25], 32'hAAAA);
    chk("R3 word 10", mem[10], 32'hBBBB);
  endtask

  task automatic t_load_mix;
    run(4'hF, e_fe(2), e_ld(0, 0), e_ldt(0), e_ld(1, 5), 25, 0, 0, 0);
    chk("R9 stall n+1 (3 loads)", 32'(g_stall_cyc), 4);
    chk("R9 order lane1", g_acc_addr[0], 10);
    chk("R9 order lane2", g_acc_addr[1], 25);
    chk("R9 order lane3", g_acc_addr[2], 25);
    chk("R2 reads only", 32'({g_acc_we[0], g_acc_we[1], g_acc_we[2]}), 0);
    chk("R2 push all", 32'(g_push), 32'hF);
    chk("R5 lane0 fetch", g_data[0], 30);
    chk("R2 lane1 load", g_data[1], 32'hBBBB);
    chk("R4 lane2 load via top", g_data[2], 32'hAAAA);
    chk("R2 lane3 load", g_data[3], 32'hAAAA);
    chk("R9 quiet during stall", 32'(g_quiet_bad), 0);
  endtask

  task automatic t_old_value;
    run(4'b0011, e_set(1), e_fe(1), 8'h00, 8'h00, 100, 0, 0, 0);
    chk("R7 fetch sees old value", g_data[1], 20);
    chk("R7 pop/push lanes", 32'({g_pop, g_push}), 32'h12);
    exp_adr[1] = 100;
  endtask

  task automatic t_conflict;
    run(4'b1101, e_set(2), 8'h00, e_add(2), e_set(2), 7, 0, 5, 9);
    chk("R8 pops lanes 0,3", 32'(g_pop), 32'b1001);
    exp_adr[2] = 9;
    run(4'b0110, 8'h00, e_set(3), e_add(3), 8'h00, 0, 50, 3, 0);
    chk("R6 add does not pop", 32'(g_pop), 32'b0010);
    chk("R6 add does not push", 32'(g_push), 0);
    exp_adr[3] = 43;
    fetch_all("R8 R7");
  endtask

  task automatic t_wrap;
    run(4'b0001, e_set(0), 8'h00, 8'h00, 8'h00, 32'hFFFF_FFFE, 0, 0, 0);
    run(4'b0001, e_st(0, 3), 8'h00, 8'h00, 8'h00, 32'h1234, 0, 0, 0);
    chk("R11 offset wraps", g_acc_addr[0], 1);
    run(4'b0010, 8'h00, e_ldt(1), 8'h00, 8'h00, 0, 1, 0, 0);
    chk("R4 load via own top", g_data[1], 32'h1234);
    run(4'b0001, e_add(0), 8'h00, 8'h00, 8'h00, 5, 0, 0, 0);
    exp_adr[0] = 3;
    fetch_all("R11 add wraps");
  endtask

  task automatic t_ignored;
    run(4'b0000, e_st(0, 0), e_ld(0, 0), e_set(0), e_add(1), 1, 2, 3, 4);
    chk("R10 invalid no request", 32'(g_req0), 0);
    chk("R10 invalid no stall", 32'(g_stall_cyc), 0);
    chk("R10 invalid no push/pop", 32'({g_push, g_pop}), 0);
    run(4'hF, 8'h90, 8'hA3, 8'hFF, 8'hBC, 1, 2, 3, 4);
    chk("R10 unassigned no request", 32'(g_req0), 0);
    chk("R10 unassigned no stall", 32'(g_stall_cyc), 0);
    chk("R10 unassigned no push/pop", 32'({g_push, g_pop}), 0);
    fetch_all("R10 registers unchanged");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_set_and_cross_fetch();
    t_store();
    t_load_mix();
    t_old_value();
    t_conflict();
    t_wrap();
    t_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule